// File: doc/BRIEF.md
# Program Counter with Push-Down Return Stack

This block keeps the 14-bit program counter of a small processor together with a private stack of seven saved return addresses. The instruction decoder drives one operation per clock: step the counter, jump, call, return, or restart to a fixed vector. Jump, call and return can be made conditional. A condition-pass bit from the flag evaluator then decides whether the operation takes effect. Jump and call targets are presented as a low address byte and a high address byte. Restarts take a 3-bit vector number.

The decoder steps the counter across every byte it fetches. When it issues a call or restart, the counter therefore already points past the instruction, and that value is saved as the return address. A restart byte forced onto the bus by an interrupt controller is fetched without stepping the counter. It is then issued as an ordinary restart, so the saved address is the one of the interrupted instruction. The stack does not live in memory. It is a ring of seven registers. Overflow and underflow wrap silently and raise no flag.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 and the stack pointer returns to its base slot.
- R2: Operations are coded on `op_i` as 0 hold, 1 step, 2 jump, 3 call, 4 return and 5 restart. A step adds 1 to the counter, and 3FFFh steps to 0000h.
- R3: A taken jump loads the counter with `{tgt_hi_i[5:0], tgt_lo_i}`. Bits 7:6 of the high byte have no effect.
- R4: A taken call saves the current counter value on the stack and loads the counter with the target formed as in R3.
- R5: A taken return loads the counter with the most recently saved entry and removes it from the stack.
- R6: A restart always takes effect, whatever `cond_i` and `pass_i` are. It saves the current counter and loads `rst_num_i` × 8 (00h, 08h … 38h).
- R7: With `cond_i` high and `pass_i` low, a jump, call or return leaves the counter unchanged and does not touch the stack. With `cond_i` low, the operation is taken whatever `pass_i` is.
- R8: A restart forced in by an interrupt, issued with no step before it, behaves like any restart. A later return resumes at the interrupted address.
- R9: Up to seven nested saves come back in reverse order.
- R10: An eighth nested save overwrites the oldest entry. Seven returns then give the seven newest addresses, and the next return gives the eighth one again.
- R11: A return with no saved entry loads whatever stale value sits in the slot below the pointer. It raises no error, and operation continues normally afterwards.
- R12: A hold, or an unused code (6 or 7), leaves the counter and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (see R2) |
| cond_i | input | 1 | Marks a jump, call or return as conditional |
| pass_i | input | 1 | Condition result from the flag evaluator |
| tgt_lo_i | input | 8 | Low byte of the jump or call target |
| tgt_hi_i | input | 8 | High byte of the jump or call target; bits 5:0 are used |
| rst_num_i | input | 3 | Restart vector number N |
| pc_o | output | 14 | Current program counter |

## Verification
Straight-line stepping and jumps, including a jump to the top address followed by a step, separate the counter's own arithmetic and target assembly from any stack traffic. Each of the three conditional operations is issued with a failing condition and then with a passing one. A return issued later shows whether the failed call touched the stack. Nesting runs seven deep, then eight deep, then one pop beyond empty. These runs tell correct reverse ordering apart from ring wrap and from stale-slot reads. Restart is tried after a step, as in a program, and without one, as for an interrupt. This shows that the saved address is simply whatever the counter held.

// File: rtl/rstk_pkg.sv
`timescale 1ns/1ps
// Shared types for the program counter and return stack.
// Assumes: op codes are stable for the whole cycle they are presented.
package rstk_pkg;
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_STEP = 3'd1,
        OP_JUMP = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_RST  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_STEP,
        SEL_TGT,
        SEL_VEC,
        SEL_POP
    } nxt_sel_e;
endpackage

// File: rtl/rstk_target.sv
`timescale 1ns/1ps
// Forms the two non-sequential destinations: the jump/call target from
// a low and high byte, and the restart vector from its number.
// Assumes: ADDR_W > 8 and VEC_W + VEC_SHIFT <= ADDR_W.
module rstk_target #(
    parameter int ADDR_W    = 14,
    parameter int VEC_W     = 3,
    parameter int VEC_SHIFT = 3
) (
    input  logic [7:0]        lo_i,
    input  logic [7:0]        hi_i,
    input  logic [VEC_W-1:0]  num_i,
    output logic [ADDR_W-1:0] tgt_o,
    output logic [ADDR_W-1:0] vec_o
);
    localparam int HI_USE = ADDR_W - 8;

    logic unused_hi_bits;
    assign unused_hi_bits = &{1'b0, hi_i[7:HI_USE]};

    // Target: low byte plus the used bits of the high byte.
    assign tgt_o = {hi_i[HI_USE-1:0], lo_i};

    // Vector: number scaled by the vector spacing, zero elsewhere.
    always_comb begin
        vec_o = '0;
        vec_o[VEC_SHIFT +: VEC_W] = num_i;
    end
endmodule

// File: rtl/rstk_ctrl.sv
`timescale 1ns/1ps
// Decodes the operation and condition into a next-counter select and
// stack push/pop strobes. Restart ignores the condition inputs.
// Assumes: unused codes behave as hold.
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       cond_i,
    input  logic       pass_i,
    output nxt_sel_e   sel_o,
    output logic       push_o,
    output logic       pop_o
);
    logic taken;
    assign taken = !cond_i || pass_i;

    // Per-operation choice of next counter source and stack action.
    always_comb begin
        sel_o  = SEL_HOLD;
        push_o = 1'b0;
        pop_o  = 1'b0;
        case (op_i)
            OP_STEP: sel_o = SEL_STEP;
            OP_JUMP: if (taken) sel_o = SEL_TGT;
            OP_CALL: if (taken) begin
                sel_o  = SEL_TGT;
                push_o = 1'b1;
            end
            OP_RET:  if (taken) begin
                sel_o = SEL_POP;
                pop_o = 1'b1;
            end
            OP_RST: begin
                sel_o  = SEL_VEC;
                push_o = 1'b1;
            end
            default: sel_o = SEL_HOLD;
        endcase
    end
endmodule

// File: rtl/rstk_ring.sv
`timescale 1ns/1ps
// Ring of DEPTH saved addresses with a wrapping pointer. Push writes the
// slot at the pointer and advances; pop retreats. The top entry is the
// slot below the pointer. No overflow or underflow detection.
// Assumes: push and pop are never high together; slots are not reset.
module rstk_ring #(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  below;
    logic [ADDR_W-1:0] slot [DEPTH];

    assign below = (ptr_q == '0) ? LAST : ptr_q - 1'b1;

    // Pointer: advance on push, retreat on pop, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (push_i)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        else if (pop_i)
            ptr_q <= below;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [ADDR_W-1:0] ent_q;
        // Slot i: captures the pushed address when the pointer sits here.
        always_ff @(posedge clk) begin
            if (push_i && ptr_q == PTR_W'(i))
                ent_q <= wdata_i;
        end
        assign slot[i] = ent_q;
    end

    assign top_o = slot[below];
endmodule

// File: rtl/ret_addr_stack.sv
`timescale 1ns/1ps
// Program counter with a seven-level push-down return stack. One
// operation per clock from the decoder; the counter is the only output.
// Assumes: the decoder has already stepped the counter past a call or
// restart instruction, so the current value is the return address.
module ret_addr_stack
    import rstk_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DEPTH     = 7,
    parameter int VEC_W     = 3,
    parameter int VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              cond_i,
    input  logic              pass_i,
    input  logic [7:0]        tgt_lo_i,
    input  logic [7:0]        tgt_hi_i,
    input  logic [VEC_W-1:0]  rst_num_i,
    output logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] vec;
    logic [ADDR_W-1:0] top;
    nxt_sel_e          sel;
    logic              push;
    logic              pop;

    rstk_target #(
        .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT)
    ) u_target (
        .lo_i(tgt_lo_i), .hi_i(tgt_hi_i), .num_i(rst_num_i),
        .tgt_o(tgt), .vec_o(vec)
    );

    rstk_ctrl u_ctrl (
        .op_i(op_i), .cond_i(cond_i), .pass_i(pass_i),
        .sel_o(sel), .push_o(push), .pop_o(pop)
    );

    rstk_ring #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH)
    ) u_ring (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .wdata_i(pc_q), .top_o(top)
    );

    // Counter register: selects the next address chosen by the decode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else begin
            case (sel)
                SEL_STEP: pc_q <= pc_q + 1'b1;
                SEL_TGT:  pc_q <= tgt;
                SEL_VEC:  pc_q <= vec;
                SEL_POP:  pc_q <= top;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/ret_addr_stack_chk.sv
`timescale 1ns/1ps
// Port-level checker for ret_addr_stack, attached by bind below.
module ret_addr_stack_chk #(
    parameter int ADDR_W    = 14,
    parameter int VEC_W     = 3,
    parameter int VEC_SHIFT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              cond_i,
    input logic              pass_i,
    input logic [7:0]        tgt_lo_i,
    input logic [7:0]        tgt_hi_i,
    input logic [VEC_W-1:0]  rst_num_i,
    input logic [ADDR_W-1:0] pc_o
);
    localparam int HI_USE = ADDR_W - 8;

    logic taken;
    assign taken = !cond_i || pass_i;

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd1 |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && taken) |=>
        pc_o == {$past(tgt_hi_i[HI_USE-1:0]), $past(tgt_lo_i)});

    a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && taken) |=>
        pc_o == {$past(tgt_hi_i[HI_USE-1:0]), $past(tgt_lo_i)});

    a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd5 |=>
        (pc_o[VEC_SHIFT +: VEC_W] == $past(rst_num_i)) &&
        ((pc_o & ~(ADDR_W'({VEC_W{1'b1}}) << VEC_SHIFT)) == '0));

    a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {3'd2, 3'd3, 3'd4} && cond_i && !pass_i) |=> $stable(pc_o));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        op_i inside {3'd0, 3'd6, 3'd7} |=> $stable(pc_o));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i),
    .pass_i(pass_i), .tgt_lo_i(tgt_lo_i), .tgt_hi_i(tgt_hi_i),
    .rst_num_i(rst_num_i), .pc_o(pc_o)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
// Scoreboard bench: issue() computes the expected counter from a
// behavioural model of the requirements and queues it; the monitor
// compares each queued value in the cycle the design updates.
module tb_ret_addr_stack;
    localparam int AW = 14;
    localparam int DP = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic          cond = 1'b0;
    logic          pass = 1'b0;
    logic [7:0]    lo = 8'd0;
    logic [7:0]    hi = 8'd0;
    logic [2:0]    num = 3'd0;
    logic [AW-1:0] pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    // Behavioural model of counter and ring.
    int m_pc = 0;
    int m_sp = 0;
    int m_stk [DP];

    always #10 clk = ~clk;

    ret_addr_stack dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .cond_i(cond), .pass_i(pass),
        .tgt_lo_i(lo), .tgt_hi_i(hi), .rst_num_i(num), .pc_o(pc)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: pc actual %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic m_push(input int v);
        m_stk[m_sp] = v;
        m_sp = (m_sp == DP - 1) ? 0 : m_sp + 1;
    endtask

    function automatic int m_pop();
        m_sp = (m_sp == 0) ? DP - 1 : m_sp - 1;
        return m_stk[m_sp];
    endfunction

    // Driver: present one operation and queue the expected counter.
    task automatic issue(input int o, input bit c, input bit p,
                         input int l, input int h, input int n,
                         input string tag);
        bit tk;
        @(negedge clk);
        op = 3'(o); cond = c; pass = p; lo = 8'(l); hi = 8'(h); num = 3'(n);
        tk = !c || p;
        case (o)
            1: m_pc = (m_pc + 1) & 16'h3FFF;
            2: if (tk) m_pc = ((h & 8'h3F) << 8) | (l & 8'hFF);
            3: if (tk) begin
                m_push(m_pc);
                m_pc = ((h & 8'h3F) << 8) | (l & 8'hFF);
            end
            4: if (tk) m_pc = m_pop();
            5: begin
                m_push(m_pc);
                m_pc = n * 8;
            end
            default: ;
        endcase
        exp_q.push_back(m_pc);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        op = 3'd0;
        exp_q.push_back(m_pc);
        tag_q.push_back("R12");
    endtask

    // Monitor: mid-high-phase compare after the updating edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(pc), e, t);
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(pc), 0, "R1");
        rst_n = 1'b1;
        m_pc = 0; m_sp = 0;

        // R2 stepping
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(1, 0, 0, 0, 0, 0, "R2");
        // R3 jump, upper high bits ignored
        issue(2, 0, 0, 8'h34, 8'hFF, 0, "R3");
        issue(2, 0, 1, 8'hFF, 8'h3F, 0, "R3");
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(2, 0, 0, 8'h00, 8'h01, 0, "R3");
        // R4/R5 call and return
        issue(3, 0, 0, 8'h34, 8'h12, 0, "R4");
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(4, 0, 0, 0, 0, 0, "R5");
        // R7 failing conditions, then passing ones
        issue(2, 1, 0, 8'h55, 8'h05, 0, "R7");
        issue(3, 1, 0, 8'h66, 8'h06, 0, "R7");
        issue(4, 1, 0, 0, 0, 0, "R7");
        issue(3, 1, 1, 8'h00, 8'h20, 0, "R7");
        issue(3, 0, 0, 8'h10, 8'h21, 0, "R7");
        issue(4, 1, 1, 0, 0, 0, "R7");
        issue(4, 0, 0, 0, 0, 0, "R7");
        // R6 program restart after a step, conditions ignored
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(5, 1, 0, 0, 0, 5, "R6");
        issue(1, 0, 0, 0, 0, 0, "R2");
        issue(4, 0, 0, 0, 0, 0, "R6");
        issue(5, 0, 0, 0, 0, 0, "R6");
        issue(4, 0, 0, 0, 0, 0, "R6");
        // R8 interrupt-forced restart, no step before it
        issue(2, 0, 0, 8'hA7, 8'h15, 0, "R3");
        issue(5, 0, 0, 0, 0, 7, "R8");
        issue(1, 0, 0, 0, 0, 0, "R8");
        issue(4, 0, 0, 0, 0, 0, "R8");
        // R9 seven-deep nesting, reverse return order
        for (int i = 0; i < 7; i++) issue(3, 0, 0, 8'h10 + i, 8'h30 + i, 0, "R9");
        for (int i = 0; i < 7; i++) issue(4, 0, 0, 0, 0, 0, "R9");
        // R11 return with nothing saved: stale slot, then normal use
        issue(4, 0, 0, 0, 0, 0, "R11");
        issue(3, 0, 0, 8'h77, 8'h07, 0, "R11");
        issue(4, 0, 0, 0, 0, 0, "R11");
        // R12 hold and unused codes
        issue(0, 0, 1, 8'hFF, 8'hFF, 7, "R12");
        issue(6, 0, 1, 8'hFF, 8'hFF, 7, "R12");
        issue(7, 1, 1, 8'hFF, 8'hFF, 7, "R12");
        issue(4, 0, 0, 0, 0, 0, "R12");
        // R1 reset mid-run clears the pointer to its base
        @(negedge clk);
        op = 3'd0;
        rst_n = 1'b0;
        @(negedge clk);
        check(int'(pc), 0, "R1");
        rst_n = 1'b1;
        m_pc = 0; m_sp = 0;
        // R10 eight nested saves overwrite the oldest
        for (int i = 0; i < 8; i++) issue(3, 0, 0, 8'h40 + i, 8'h02 + i, 0, "R10");
        for (int i = 0; i < 8; i++) issue(4, 0, 0, 0, 0, 0, "R10");
        idle();
        idle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule